// File: doc/BRIEF.md
# Ping-pong block data buffer with 16/32-bit CPU bridge

This block sits between a card-side block mover and a CPU or DMA port. It holds two 16-bit FIFOs of one block each, used in alternation. The card side fills the FIFO that the CPU is not currently reading. Ownership swaps automatically once the CPU side has drained and the other FIFO holds a full block. An optional 32-bit FIFO acts as a packing bridge. In the receive direction it joins pairs of 16-bit words. In the transmit direction it splits 32-bit words back into halves. This lets a 32-bit CPU or DMA engine move the data at twice the width.

The block produces event pulses for the surrounding controller. These cover received data ready, a transmit request that finds no data, the 32-bit level interrupt, and the end of each block. The block-end pulse either asks for the next block or reports that the transfer is done, with an optional stop-command request. A DMA request is held while the 32-bit FIFO holds a whole 32-bit block. The 32-bit control word has three stored bits: bit 1 is the wide enable, bit 11 enables the full-level flag and bit 12 enables the empty flag. Bit 10 is a write-only flush. Status reads back those stored bits together with bit 8 (level reached) and bit 9 (not empty).

Top module: `pp_data_fifo`

## Requirements
- R1: After reset, both 16-bit FIFOs and the 32-bit FIFO are empty. Every output and event pulse is 0, and the status word reads 0x0000.
- R2: A word pushed by the card side goes into the FIFO that is not selected for the CPU. It cannot be read by the CPU before that FIFO holds a full block (block length in bytes / 2 words).
- R3: When the CPU-side store is empty (the 16-bit FIFO, or the 32-bit FIFO in wide mode) and the other FIFO holds a full block, selection toggles on the next clock edge. In 16-bit mode, `rx_ready` pulses for one cycle after that edge. It never pulses in wide mode.
- R4: A second block received while the CPU still holds the first is read only after the first is drained, in order.
- R5: Wide mode is on only while `wide_sel` and control bit 1 are both 1. Otherwise 32-bit writes are ignored and 32-bit reads return 0.
- R6: In receive wide mode, two 16-bit words move into one 32-bit entry, with the first word in bits 15:0. Movement stops once the 32-bit FIFO holds block length / 4 entries, and the rest stays in the 16-bit FIFO.
- R7: Status bit 8 is 1 when the 32-bit level is at least block length / 4, and bit 9 is 1 when the 32-bit FIFO is not empty. `dma_req` is high while wide mode holds a full 32-bit block.
- R8: `irq32` pulses for one cycle when the pair {bit 8 AND enable bit 11, NOT bit 9 AND enable bit 12} changes from all-zero to non-zero in wide mode.
- R9: A control write stores only bits 12, 11 and 1 (mask 0x1802). Writing bit 10 as 1 empties the 32-bit FIFO.
- R10: `tx_empty` pulses when `tx_want` is high and the CPU-side store is empty. The store is the 16-bit FIFO, or the 32-bit FIFO in wide mode.
- R11: When a CPU read empties the CPU-side store in receive, or a card read empties it in transmit, the block ends. With count at most 1, `blk_done` pulses, and `stop_req` pulses with it if `stop_ena` is set. Otherwise the count decrements and `next_blk` pulses.
- R12: Writes into a full FIFO are dropped, and reads of an empty FIFO return 0 without other effect.
- R13: In transmit, the card reads words of the selected FIFO in order, and draining it toggles the selection. In wide mode, each 32-bit entry is split low half first, up to one block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_len16 | input | 10 | 16-bit block length in bytes |
| blk_len32 | input | 10 | 32-bit block length in bytes |
| wide_sel | input | 1 | Data-control wide bit |
| xfer_tx | input | 1 | 1 = transmit direction |
| ctl32_we | input | 1 | Write strobe for 32-bit control word |
| ctl32_wdata | input | 16 | 32-bit control write data |
| stat32 | output | 16 | 32-bit control/status readback |
| cnt_we | input | 1 | Load block count |
| cnt_wdata | input | 16 | Block count value |
| stop_ena | input | 1 | Request stop command at the end |
| rx_wr | input | 1 | Card pushes a received word |
| rx_data | input | 16 | Received word |
| tx_rd | input | 1 | Card pops a word to transmit |
| tx_data | output | 16 | Head of CPU-side FIFO, 0 when empty |
| tx_want | input | 1 | Card wants transmit data |
| cpu16_rd | input | 1 | CPU 16-bit read strobe |
| cpu16_wr | input | 1 | CPU 16-bit write strobe |
| cpu16_wdata | input | 16 | CPU 16-bit write data |
| cpu16_rdata | output | 16 | CPU 16-bit read data |
| cpu32_rd | input | 1 | CPU 32-bit read strobe |
| cpu32_wr | input | 1 | CPU 32-bit write strobe |
| cpu32_wdata | input | 32 | CPU 32-bit write data |
| cpu32_rdata | output | 32 | CPU 32-bit read data |
| rx_ready | output | 1 | Received block ready pulse |
| tx_empty | output | 1 | Transmit request on empty pulse |
| irq32 | output | 1 | 32-bit level interrupt pulse |
| dma_req | output | 1 | 32-bit block available |
| blk_done | output | 1 | Transfer finished pulse |
| stop_req | output | 1 | Stop command request pulse |
| next_blk | output | 1 | Next block request pulse |

## Verification
The bench builds the block with 8-entry 16-bit FIFOs and a 16-byte block, so one block fills a FIFO exactly. This makes every FIFO full and empty boundary reachable in a few cycles. The overflow drop then shows directly as a corrupted or extra word. Setting the 32-bit block to 8 bytes, half of the 16-bit block, exercises the packing stop with data left behind. Setting both lengths to 16 bytes gives a single wide block per 16-bit block.

// File: rtl/sdpp_pkg.sv
package sdpp_pkg;

    localparam logic [15:0] CTL32_KEEP  = 16'h1802;
    localparam int          FLUSH_BIT   = 10;

    typedef struct packed {
        logic en_empty;   // bit 12
        logic en_full;    // bit 11
        logic wide;       // bit 1
    } ctl32_t;

    typedef enum logic [1:0] {
        BR_IDLE   = 2'd0,
        BR_PACK   = 2'd1,
        BR_UNPACK = 2'd2
    } br_op_e;

    function automatic ctl32_t ctl32_decode(input logic [15:0] w);
        logic [15:0] k;
        k = w & CTL32_KEEP;
        return '{en_empty: k[12], en_full: k[11], wide: k[1]};
    endfunction

    function automatic logic [15:0] stat32_word(input ctl32_t c,
                                                input logic lvl_hit,
                                                input logic not_empty);
        logic [15:0] s;
        s      = '0;
        s[12]  = c.en_empty;
        s[11]  = c.en_full;
        s[9]   = not_empty;
        s[8]   = lvl_hit;
        s[1]   = c.wide;
        return s;
    endfunction

endpackage

// File: rtl/pp_fifo.sv
module pp_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    parameter int LANES = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clr,
    input  logic [1:0]             push_n,
    input  logic [1:0]             pop_n,
    input  logic [LANES*W-1:0]     din,
    output logic [LANES*W-1:0]     dout,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rp, wp;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            rp    <= '0;
            wp    <= '0;
            level <= '0;
        end else begin
            wp    <= wp + AW'(push_n);
            rp    <= rp + AW'(pop_n);
            level <= level + LW'(push_n) - LW'(pop_n);
        end
    end

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            always_ff @(posedge clk) begin
                if (!rst && !clr && (push_n > 2'(g)))
                    mem[wp + AW'(g)] <= din[g*W +: W];
            end
            assign dout[g*W +: W] = mem[rp + AW'(g)];
        end
    endgenerate

endmodule

// File: rtl/pp_blkseq.sv
module pp_blkseq #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             stop_ena,
    input  logic             blk_end,
    output logic             blk_done,
    output logic             stop_req,
    output logic             next_blk
);
    logic [CNT_W-1:0] cnt;
    logic             last;

    assign last = (cnt <= CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            blk_done <= 1'b0;
            stop_req <= 1'b0;
            next_blk <= 1'b0;
        end else begin
            blk_done <= blk_end && last;
            stop_req <= blk_end && last && stop_ena;
            next_blk <= blk_end && !last;
            if (cnt_we)
                cnt <= cnt_wdata;
            else if (blk_end && !last)
                cnt <= cnt - CNT_W'(1);
        end
    end

endmodule

// File: rtl/pp_data_fifo.sv
module pp_data_fifo
    import sdpp_pkg::*;
#(
    parameter int DEPTH16 = 256,
    parameter int CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [9:0]       blk_len16,
    input  logic [9:0]       blk_len32,
    input  logic             wide_sel,
    input  logic             xfer_tx,
    input  logic             ctl32_we,
    input  logic [15:0]      ctl32_wdata,
    output logic [15:0]      stat32,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             stop_ena,
    input  logic             rx_wr,
    input  logic [15:0]      rx_data,
    input  logic             tx_rd,
    output logic [15:0]      tx_data,
    input  logic             tx_want,
    input  logic             cpu16_rd,
    input  logic             cpu16_wr,
    input  logic [15:0]      cpu16_wdata,
    output logic [15:0]      cpu16_rdata,
    input  logic             cpu32_rd,
    input  logic             cpu32_wr,
    input  logic [31:0]      cpu32_wdata,
    output logic [31:0]      cpu32_rdata,
    output logic             rx_ready,
    output logic             tx_empty,
    output logic             irq32,
    output logic             dma_req,
    output logic             blk_done,
    output logic             stop_req,
    output logic             next_blk
);
    localparam int DEPTH32 = DEPTH16 / 2;
    localparam int LW16    = $clog2(DEPTH16 + 1);
    localparam int LW32    = $clog2(DEPTH32 + 1);
    localparam logic [10:0] D16 = 11'(DEPTH16);
    localparam logic [10:0] D32 = 11'(DEPTH32);

    // ---------------- state ----------------
    logic   sel;
    ctl32_t ctl;
    logic   mode32;
    logic [1:0] flags_q;
    logic   rdy_q;
    logic   txc_q;

    // ---------------- fifo wiring ----------------
    logic [LW16-1:0] lvl16 [2];
    logic [31:0]     h16   [2];
    logic [31:0]     d16   [2];
    logic [1:0]      push16[2];
    logic [1:0]      pop16 [2];

    logic [LW32-1:0] lvl32;
    logic [31:0]     h32, din32;
    logic [1:0]      push32, pop32;

    logic [LW16-1:0] lvl_cur, lvl_oth;
    logic [10:0]     cur_x, oth_x, l32_x, bw16, bw32;

    assign mode32  = wide_sel && ctl.wide;
    assign lvl_cur = lvl16[sel];
    assign lvl_oth = lvl16[~sel];
    assign cur_x   = 11'(lvl_cur);
    assign oth_x   = 11'(lvl_oth);
    assign l32_x   = 11'(lvl32);
    assign bw16    = 11'(blk_len16 >> 1);
    assign bw32    = 11'(blk_len32 >> 2);

    // ---------------- access qualification ----------------
    logic c16_rd_ok, c16_wr_ok, tx_rd_ok, rx_ok;
    logic c32_rd_ok, c32_wr_ok, flush;
    logic busy_cur, busy32;
    logic cur_empty, swap, tx_end, rx_end;
    br_op_e br_op;

    assign flush     = ctl32_we && ctl32_wdata[FLUSH_BIT];
    assign c16_rd_ok = cpu16_rd && (cur_x != 11'd0);
    assign c16_wr_ok = cpu16_wr && (cur_x < D16);
    assign tx_rd_ok  = tx_rd    && (cur_x != 11'd0);
    assign rx_ok     = rx_wr    && (oth_x < D16);
    assign c32_rd_ok = mode32 && cpu32_rd && (l32_x != 11'd0);
    assign c32_wr_ok = mode32 && cpu32_wr && (l32_x < D32);

    assign busy_cur  = cpu16_rd || cpu16_wr || tx_rd;
    assign busy32    = cpu32_rd || cpu32_wr || flush;

    always_comb begin
        br_op = BR_IDLE;
        if (mode32 && !busy_cur && !busy32) begin
            if (!xfer_tx && (l32_x < bw32) && (l32_x < D32) && (cur_x >= 11'd2))
                br_op = BR_PACK;
            else if (xfer_tx && (l32_x != 11'd0) &&
                     (cur_x + 11'd2 <= bw16) && (cur_x + 11'd2 <= D16))
                br_op = BR_UNPACK;
        end
    end

    assign cur_empty = mode32 ? (l32_x == 11'd0) : (cur_x == 11'd0);
    assign swap      = !xfer_tx && cur_empty && (bw16 != 11'd0) && (oth_x >= bw16);
    assign tx_end    = tx_rd_ok && (cur_x == 11'd1);
    assign rx_end    = !xfer_tx &&
                       (mode32 ? (c32_rd_ok && (l32_x == 11'd1))
                               : (c16_rd_ok && (cur_x == 11'd1)));

    // ---------------- 16-bit fifo controls ----------------
    always_comb begin
        for (int i = 0; i < 2; i++) begin
            push16[i] = 2'd0;
            pop16[i]  = 2'd0;
            d16[i]    = {16'h0000, cpu16_wdata};
            if (1'(i) == sel) begin
                if (c16_wr_ok)
                    push16[i] = 2'd1;
                else if (br_op == BR_UNPACK) begin
                    push16[i] = 2'd2;
                    d16[i]    = h32;
                end
                if (c16_rd_ok || tx_rd_ok)
                    pop16[i] = 2'd1;
                else if (br_op == BR_PACK)
                    pop16[i] = 2'd2;
            end else if (rx_ok) begin
                push16[i] = 2'd1;
                d16[i]    = {16'h0000, rx_data};
            end
        end
    end

    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_half
            pp_fifo #(.W(16), .DEPTH(DEPTH16), .LANES(2)) u_f16 (
                .clk    (clk),
                .rst    (rst),
                .clr    (1'b0),
                .push_n (push16[g]),
                .pop_n  (pop16[g]),
                .din    (d16[g]),
                .dout   (h16[g]),
                .level  (lvl16[g])
            );
        end
    endgenerate

    // ---------------- 32-bit fifo ----------------
    always_comb begin
        push32 = 2'd0;
        pop32  = 2'd0;
        din32  = cpu32_wdata;
        if (c32_wr_ok)
            push32 = 2'd1;
        else if (br_op == BR_PACK) begin
            push32 = 2'd1;
            din32  = h16[sel];
        end
        if (c32_rd_ok || (br_op == BR_UNPACK))
            pop32 = 2'd1;
    end

    pp_fifo #(.W(32), .DEPTH(DEPTH32), .LANES(1)) u_f32 (
        .clk    (clk),
        .rst    (rst),
        .clr    (flush),
        .push_n (push32),
        .pop_n  (pop32),
        .din    (din32),
        .dout   (h32),
        .level  (lvl32)
    );

    // ---------------- block sequencing ----------------
    pp_blkseq #(.CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cnt_we    (cnt_we),
        .cnt_wdata (cnt_wdata),
        .stop_ena  (stop_ena),
        .blk_end   (rx_end || tx_end),
        .blk_done  (blk_done),
        .stop_req  (stop_req),
        .next_blk  (next_blk)
    );

    // ---------------- flags and registers ----------------
    logic       lvl_hit, not_empty, tx_cond;
    logic [1:0] flags;

    assign lvl_hit   = (l32_x >= bw32);
    assign not_empty = (l32_x != 11'd0);
    assign flags     = mode32 ? {!not_empty && ctl.en_empty, lvl_hit && ctl.en_full} : 2'b00;
    assign tx_cond   = tx_want && cur_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel     <= 1'b0;
            ctl     <= '0;
            flags_q <= '0;
            rdy_q   <= 1'b0;
            txc_q   <= 1'b0;
        end else begin
            if (swap || tx_end)
                sel <= ~sel;
            if (ctl32_we)
                ctl <= ctl32_decode(ctl32_wdata);
            flags_q <= flags;
            rdy_q   <= swap && !mode32;
            txc_q   <= tx_cond;
        end
    end

    assign stat32      = stat32_word(ctl, lvl_hit, not_empty);
    assign cpu16_rdata = (cur_x != 11'd0) ? h16[sel][15:0] : 16'h0000;
    assign tx_data     = cpu16_rdata;
    assign cpu32_rdata = (mode32 && not_empty) ? h32 : 32'h0;
    assign rx_ready    = rdy_q;
    assign tx_empty    = tx_cond && !txc_q;
    assign irq32       = (flags != 2'b00) && (flags_q == 2'b00);
    assign dma_req     = mode32 && lvl_hit && (bw32 != 11'd0);

endmodule

// File: rtl/pp_data_fifo_chk.sv
module pp_data_fifo_chk #(
    parameter int LW16    = 9,
    parameter int LW32    = 8,
    parameter int DEPTH32 = 128
) (
    input logic            clk,
    input logic            rst,
    input logic            sel,
    input logic            xfer_tx,
    input logic            tx_rd,
    input logic [LW16-1:0] lvl_cur,
    input logic [LW32-1:0] lvl32,
    input logic            blk_done,
    input logic            stop_req,
    input logic            next_blk,
    input logic            dma_req,
    input logic [15:0]     stat32,
    input logic            ctl32_we,
    input logic [15:0]     ctl32_wdata
);
    p_one_event_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({blk_done, next_blk}));

    p_stop_with_done_r11: assert property (@(posedge clk) disable iff (rst)
        stop_req |-> blk_done);

    p_no_overflow_r12: assert property (@(posedge clk) disable iff (rst)
        32'(lvl32) <= DEPTH32);

    p_dma_nonempty_r7: assert property (@(posedge clk) disable iff (rst)
        dma_req |-> stat32[9]);

    p_flush_r9: assert property (@(posedge clk) disable iff (rst)
        (ctl32_we && ctl32_wdata[10]) |=> !stat32[9]);

    p_tx_toggle_r13: assert property (@(posedge clk) disable iff (rst)
        (xfer_tx && tx_rd && (lvl_cur == LW16'(1))) |=> (sel != $past(sel)));

endmodule

bind pp_data_fifo pp_data_fifo_chk #(.LW16(LW16), .LW32(LW32), .DEPTH32(DEPTH32)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sel         (sel),
    .xfer_tx     (xfer_tx),
    .tx_rd       (tx_rd),
    .lvl_cur     (lvl_cur),
    .lvl32       (lvl32),
    .blk_done    (blk_done),
    .stop_req    (stop_req),
    .next_blk    (next_blk),
    .dma_req     (dma_req),
    .stat32      (stat32),
    .ctl32_we    (ctl32_we),
    .ctl32_wdata (ctl32_wdata)
);

// File: tb/sim_pp_data_fifo.sv
module sim_pp_data_fifo;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [9:0]  blk_len16 = 10'd16, blk_len32 = 10'd16;
    logic        wide_sel = 0, xfer_tx = 0, ctl32_we = 0, cnt_we = 0, stop_ena = 0;
    logic [15:0] ctl32_wdata = 0, cnt_wdata = 0, rx_data = 0, cpu16_wdata = 0;
    logic        rx_wr = 0, tx_rd = 0, tx_want = 0, cpu16_rd = 0, cpu16_wr = 0;
    logic        cpu32_rd = 0, cpu32_wr = 0;
    logic [31:0] cpu32_wdata = 0;
    logic [15:0] stat32, tx_data, cpu16_rdata;
    logic [31:0] cpu32_rdata;
    logic        rx_ready, tx_empty, irq32, dma_req, blk_done, stop_req, next_blk;

    int total = 0;
    int bad   = 0;

    pp_data_fifo #(.DEPTH16(8), .CNT_W(16)) u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_ctl(input logic [15:0] v);
        ctl32_we = 1; ctl32_wdata = v;
        tick();
        ctl32_we = 0;
    endtask

    task automatic set_cnt(input logic [15:0] v);
        cnt_we = 1; cnt_wdata = v;
        tick();
        cnt_we = 0;
    endtask

    task automatic rx_block(input logic [15:0] base);
        for (int i = 0; i < 8; i++) begin
            rx_wr = 1; rx_data = base + 16'(i);
            tick();
        end
        rx_wr = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int nrdy, nirq;
        repeat (3) tick();
        rst = 0;
        #1;
        // R1 reset state
        chk("R1 stat32", stat32, 0);
        chk("R1 rdata16", cpu16_rdata, 0);
        chk("R1 events", {rx_ready, tx_empty, irq32, dma_req, blk_done, stop_req, next_blk}, 0);

        // ---- 16-bit receive, two blocks ----
        stop_ena = 1;
        set_cnt(16'd2);
        for (int i = 0; i < 7; i++) begin
            rx_wr = 1; rx_data = 16'h0100 + 16'(i); tick();
        end
        rx_wr = 0; #1;
        chk("R2 partial block hidden", cpu16_rdata, 0);
        rx_wr = 1; rx_data = 16'h0107; tick(); rx_wr = 0;
        chk("R3 no ready yet", rx_ready, 0);
        tick();
        chk("R3 ready after swap", rx_ready, 1);
        tick();
        chk("R3 ready one cycle", rx_ready, 0);
        rx_block(16'h0200);
        for (int i = 0; i < 8; i++) begin
            cpu16_rd = 1; #1;
            chk("R4 first block word", cpu16_rdata, 16'h0100 + 16'(i));
            tick();
        end
        cpu16_rd = 0;
        chk("R11 next block", {next_blk, blk_done}, 2'b10);
        tick();
        chk("R3 second swap ready", rx_ready, 1);
        for (int i = 0; i < 8; i++) begin
            cpu16_rd = 1; #1;
            chk("R4 second block word", cpu16_rdata, 16'h0200 + 16'(i));
            tick();
        end
        cpu16_rd = 0;
        chk("R11 done with stop", {blk_done, stop_req, next_blk}, 3'b110);
        cpu16_rd = 1; #1;
        chk("R12 empty read zero", cpu16_rdata, 0);
        tick(); cpu16_rd = 0;
        chk("R12 empty read no event", {blk_done, next_blk}, 0);

        // ---- 16-bit transmit with overflow drop ----
        xfer_tx = 1; stop_ena = 0;
        set_cnt(16'd1);
        tx_want = 1; #1;
        chk("R10 tx empty pulse", tx_empty, 1);
        tick();
        chk("R10 tx empty single", tx_empty, 0);
        tx_want = 0;
        for (int i = 0; i < 9; i++) begin
            cpu16_wr = 1; cpu16_wdata = 16'h0300 + 16'(i); tick();
        end
        cpu16_wr = 0;
        tx_want = 1; #1;
        chk("R10 no pulse when data", tx_empty, 0);
        tx_want = 0;
        for (int i = 0; i < 8; i++) begin
            tx_rd = 1; #1;
            chk("R13 tx order", tx_data, 16'h0300 + 16'(i));
            tick();
        end
        tx_rd = 0;
        chk("R11 tx done no stop", {blk_done, stop_req}, 2'b10);
        chk("R12 ninth word dropped", tx_data, 0);

        // ---- wide mode enable ----
        xfer_tx = 0;
        set_ctl(16'h0002);
        cpu32_wr = 1; cpu32_wdata = 32'hDEAD_BEEF; tick(); cpu32_wr = 0;
        chk("R5 narrow read zero", cpu32_rdata, 0);
        chk("R5 stat narrow", stat32, 16'h0002);
        wide_sel = 1; #1;
        chk("R5 write ignored", stat32[9], 0);
        set_ctl(16'hFFFF);
        chk("R9 mask", stat32, 16'h1802);
        chk("R8 empty irq", irq32, 1);
        tick();
        chk("R8 irq one cycle", irq32, 0);

        // ---- wide receive, half block packs ----
        set_ctl(16'h0802);
        stop_ena = 1;
        blk_len32 = 10'd8;
        set_cnt(16'd1);
        nrdy = 0; nirq = 0;
        for (int i = 0; i < 8; i++) begin
            rx_wr = 1; rx_data = 16'h0400 + 16'(i);
            tick();
            nrdy += int'(rx_ready); nirq += int'(irq32);
        end
        rx_wr = 0;
        for (int i = 0; i < 10; i++) begin
            tick();
            nrdy += int'(rx_ready); nirq += int'(irq32);
        end
        chk("R3 no ready in wide", 32'(nrdy), 0);
        chk("R8 level irq once", 32'(nirq), 1);
        chk("R7 dma", dma_req, 1);
        chk("R7 level bits", stat32[9:8], 2'b11);
        chk("R6 remainder in 16", cpu16_rdata, 16'h0404);
        for (int k = 0; k < 2; k++) begin
            cpu32_rd = 1; #1;
            chk("R6 pack low first", cpu32_rdata,
                {16'h0401 + 16'(2*k), 16'h0400 + 16'(2*k)});
            tick();
            if (k == 0) chk("R7 dma drops", dma_req, 0);
        end
        cpu32_rd = 0;
        chk("R11 wide done", blk_done, 1);
        repeat (6) tick();
        for (int k = 2; k < 4; k++) begin
            cpu32_rd = 1; #1;
            chk("R6 refill", cpu32_rdata,
                {16'h0401 + 16'(2*k), 16'h0400 + 16'(2*k)});
            tick();
        end
        cpu32_rd = 0;
        chk("R12 wide empty", cpu32_rdata, 0);
        chk("R7 empty bit", stat32[9], 0);
        blk_len32 = 10'd16;

        // ---- flush ----
        cpu32_wr = 1; cpu32_wdata = 32'h1111_2222; tick();
        cpu32_wdata = 32'h3333_4444; tick(); cpu32_wr = 0;
        chk("R7 not empty", stat32[9], 1);
        set_ctl(16'h0C02);
        chk("R9 flush empties", stat32[9], 0);
        chk("R9 flush read zero", cpu32_rdata, 0);

        // ---- wide transmit ----
        xfer_tx = 1; stop_ena = 0;
        set_ctl(16'h0002);
        set_cnt(16'd1);
        tx_want = 1; #1;
        chk("R10 wide empty pulse", tx_empty, 1);
        tick(); tx_want = 0;
        for (int k = 0; k < 5; k++) begin
            cpu32_wr = 1;
            cpu32_wdata = {16'h0501 + 16'(2*k), 16'h0500 + 16'(2*k)};
            tick();
        end
        cpu32_wr = 0;
        repeat (8) tick();
        for (int i = 0; i < 8; i++) begin
            tx_rd = 1; #1;
            chk("R13 unpack order", tx_data, 16'h0500 + 16'(i));
            tick();
        end
        tx_rd = 0;
        chk("R11 wide tx done", blk_done, 1);
        repeat (3) tick();
        chk("R12 fifth entry dropped", tx_data, 0);
        chk("R12 wide fifo empty", stat32[9], 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule